// File: doc/BRIEF.md
# Reaction Time Meter

This block measures how fast a person responds to a light. Raising the arm input and holding it high starts a run. The block then waits a number of clock periods set by an 8-bit threshold input. After that wait it lights the stimulus LED and starts a four-digit decimal counter that steps once per millisecond. The counter drives four active-low seven-segment digit outputs. When the response button is pressed, the LED goes dark and the digits freeze on the measured time.

The frozen result stays on the display until the arm input returns low. A low arm input clears the display and puts the block back in its idle state. Only a rising edge of the synchronized button counts as a press, and it counts only while the light is on. A button that is pressed early or held down therefore cannot end a measurement. The millisecond period is the parameter `TICK_CYCLES`, 50,000 cycles of a 50 MHz clock by default. Debouncing and random delays are left to the surrounding logic.

Top module: `reaction_timer`

## Requirements
- R1: After reset, and whenever `start` is low, `led` is 00 and every digit shows 0, which is the segment code 7'h40.
- R2: Let E0 be the first clock edge that samples `start` high in idle, with `thresh` = N. `led[0]` rises right after edge E(N). If N is 0, that is the edge E0 itself.
- R3: While `led[0]` is high, the displayed value rises by one every `TICK_CYCLES` cycles. The first step comes `TICK_CYCLES` edges after the LED turns on, because the prescaler starts from zero.
- R4: The four digits count in decimal. `seg0` is the units digit and `seg3` is the thousands digit. The count stops at 9999 and does not wrap.
- R5: A press is a 0-to-1 change of `resp_btn` after its two-flop synchronizer. Call P0 the first edge that samples the button high. `led[0]` falls right after edge P0+2, and the display keeps the count it held just before that edge.
- R6: A press during the wait phase, a press after the result is frozen, or a button already held high when the light comes on has no effect on `led` or on the display.
- R7: `start` going low in any phase returns the block to idle. The clear shows at the ports right after the first edge that samples it low. A later high `start` begins a new wait that counts from zero.
- R8: The segment outputs are active-low. Bit 0 is segment a and bit 6 is segment g. The digits 0 to 9 use the codes 40, 79, 24, 30, 19, 12, 02, 78, 00 and 10 (hex).
- R9: `led[1]` is always 0.
- R10: While `start` is high and `led[0]` is low, the display does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Arm level; high runs a measurement, low clears |
| thresh | input | 8 | Wait length in clock periods before the light |
| resp_btn | input | 1 | Response button, asynchronous |
| led | output | 2 | Bit 0 is the stimulus light, bit 1 is held low |
| seg3 | output | 7 | Thousands digit, active-low segments a..g on bits 0..6 |
| seg2 | output | 7 | Hundreds digit |
| seg1 | output | 7 | Tens digit |
| seg0 | output | 7 | Units digit |

## Verification
Faults inside the block show at the ports in different ways. A delay counter that is off by one moves the LED turn-on edge by a whole cycle, and comparing against the exact edge for each threshold catches this. A prescaler that is not cleared on entry, or that has the wrong period, shifts the first displayed step and every later step. Checking the display on every cycle of the run exposes this within one tick period. A carry or saturation fault in the digit chain gives a wrong or undecodable digit at the moment of the carry, so one long run that goes past 9999 walks through every rollover. Errors in the press path show as an LED that goes dark on the wrong edge, or as a frozen value that differs from the expected count.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_WAIT = 2'd1,
    RT_RUN  = 2'd2,
    RT_HOLD = 2'd3
  } rt_state_e;

  // active-low pattern, bit0 = segment a ... bit6 = segment g (R8)
  function automatic logic [6:0] seg_of(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0:    on = 7'h3F;
      4'd1:    on = 7'h06;
      4'd2:    on = 7'h5B;
      4'd3:    on = 7'h4F;
      4'd4:    on = 7'h66;
      4'd5:    on = 7'h6D;
      4'd6:    on = 7'h7D;
      4'd7:    on = 7'h07;
      4'd8:    on = 7'h7F;
      4'd9:    on = 7'h6F;
      default: on = 7'h00;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/rt_delay_ctr.sv
module rt_delay_ctr #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [THR_W-1:0] thresh,
  output logic             zero_thr,
  output logic             hit
);
  logic [THR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the wait ends on the edge where the count reaches the threshold
  assign hit      = ({1'b0, cnt_q} + {{THR_W{1'b0}}, 1'b1}) >= {1'b0, thresh};
  assign zero_thr = (thresh == '0);
endmodule

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
  parameter int TICK_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] pre_q, pre_d;
  logic          wrap;

  assign wrap = (pre_q == LAST);

  // R3: prescaler held at zero outside the run phase
  always_comb begin
    pre_d = pre_q;
    if (!run)      pre_d = '0;
    else if (wrap) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run && wrap;
endmodule

// File: rtl/rt_bcd_counter.sv
module rt_bcd_counter #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  output logic [NDIG*4-1:0] digits
);
  logic [3:0]    dig_q [NDIG];
  logic [NDIG:0] carry;
  logic [NDIG-1:0] is_nine;
  logic          full;

  assign carry[0] = 1'b1;
  assign full     = &is_nine;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] nxt;
    assign is_nine[i]  = (dig_q[i] == 4'd9);
    assign carry[i+1]  = carry[i] & is_nine[i];

    // R4: ripple carry between decades, hold at all nines
    always_comb begin
      nxt = dig_q[i];
      if (clear)                     nxt = 4'd0;
      else if (inc && !full && carry[i])
        nxt = is_nine[i] ? 4'd0 : dig_q[i] + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dig_q[i] <= 4'd0;
      else        dig_q[i] <= nxt;
    end

    assign digits[i*4 +: 4] = dig_q[i];
  end
endmodule

// File: rtl/rt_seg_decode.sv
module rt_seg_decode #(
  parameter int NDIG = 4
) (
  input  logic [NDIG*4-1:0] digits,
  output logic [NDIG*7-1:0] segs
);
  import rt_pkg::*;

  for (genvar i = 0; i < NDIG; i++) begin : g_seg
    assign segs[i*7 +: 7] = seg_of(digits[i*4 +: 4]);
  end
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      zero_thr,
  input  logic      hit,
  input  logic      press,
  output rt_state_e state
);
  rt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!start) begin
      st_d = RT_IDLE;                          // R7
    end else begin
      case (st_q)
        RT_IDLE: st_d = zero_thr ? RT_RUN : RT_WAIT;
        RT_WAIT: if (hit)   st_d = RT_RUN;     // R2
        RT_RUN:  if (press) st_d = RT_HOLD;    // R5
        RT_HOLD: st_d = RT_HOLD;               // R6
        default: st_d = RT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RT_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer #(
  parameter int TICK_CYCLES = 50000,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [THR_W-1:0] thresh,
  input  logic             resp_btn,
  output logic [1:0]       led,
  output logic [6:0]       seg3,
  output logic [6:0]       seg2,
  output logic [6:0]       seg1,
  output logic [6:0]       seg0
);
  import rt_pkg::*;

  localparam int NDIG = 4;

  logic [1:0]        rst_pipe;
  logic              rst_i;
  logic [2:0]        btn_q;
  logic              press;
  logic              zero_thr, hit, tick;
  rt_state_e         state;
  logic [NDIG*4-1:0] digits;
  logic [NDIG*7-1:0] segs;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // R5: two synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) btn_q <= 3'b000;
    else        btn_q <= {btn_q[1:0], resp_btn};
  end
  // R6: a level held high produces no edge
  assign press = btn_q[1] & ~btn_q[2];

  rt_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (start),
    .zero_thr (zero_thr),
    .hit      (hit),
    .press    (press),
    .state    (state)
  );

  rt_delay_ctr #(.THR_W(THR_W)) u_delay (
    .clk      (clk),
    .rst_n    (rst_i),
    .en       (state == RT_WAIT),
    .thresh   (thresh),
    .zero_thr (zero_thr),
    .hit      (hit)
  );

  rt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_i),
    .run   (state == RT_RUN),
    .tick  (tick)
  );

  // R5: a tick coinciding with the press edge is discarded
  rt_bcd_counter #(.NDIG(NDIG)) u_bcd (
    .clk    (clk),
    .rst_n  (rst_i),
    .clear  (!start),
    .inc    (tick && !press),
    .digits (digits)
  );

  rt_seg_decode #(.NDIG(NDIG)) u_seg (
    .digits (digits),
    .segs   (segs)
  );

  assign seg0 = segs[6:0];
  assign seg1 = segs[13:7];
  assign seg2 = segs[20:14];
  assign seg3 = segs[27:21];
  assign led  = {1'b0, state == RT_RUN};   // R9
endmodule

// File: rtl/rt_checks.sv
module rt_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       resp_btn,
  input logic [1:0] led,
  input logic [6:0] seg3,
  input logic [6:0] seg2,
  input logic [6:0] seg1,
  input logic [6:0] seg0
);
  function automatic logic legal(input logic [6:0] s);
    return s inside {7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                     7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
  endfunction

  // R9
  led_hi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led[1] == 1'b0);

  // R7
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (led == 2'b00 && seg0 == 7'h40 && seg1 == 7'h40 &&
                seg2 == 7'h40 && seg3 == 7'h40));

  // R10
  dark_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !led[0]) |=> $stable({seg3, seg2, seg1, seg0}));

  // R2
  light_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led[0]) |-> $past(start));

  // R5
  dark_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led[0]) |-> (!$past(start) || $past(resp_btn, 3)));

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led[0] && start && {seg3, seg2, seg1, seg0} == {4{7'h10}})
      |=> (!start || {seg3, seg2, seg1, seg0} == {4{7'h10}}));

  // R8
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    legal(seg0) && legal(seg1) && legal(seg2) && legal(seg3));
endmodule

bind reaction_timer rt_checks u_rt_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .resp_btn (resp_btn),
  .led      (led),
  .seg3     (seg3),
  .seg2     (seg2),
  .seg1     (seg1),
  .seg0     (seg0)
);

// File: tb/reaction_timer_test.sv
module reaction_timer_test;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] thresh = 8'd0;
  logic       resp_btn = 1'b0;
  logic [1:0] led;
  logic [6:0] seg3, seg2, seg1, seg0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  reaction_timer #(.TICK_CYCLES(T)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh),
    .resp_btn(resp_btn), .led(led),
    .seg3(seg3), .seg2(seg2), .seg1(seg1), .seg0(seg0)
  );

  function automatic int dig(input logic [6:0] s);
    case (s)
      7'h40: return 0;  7'h79: return 1;  7'h24: return 2;
      7'h30: return 3;  7'h19: return 4;  7'h12: return 5;
      7'h02: return 6;  7'h78: return 7;  7'h00: return 8;
      7'h10: return 9;  default: return -1000000;
    endcase
  endfunction

  function automatic int shown();
    int v;
    v = dig(seg3) * 1000 + dig(seg2) * 100 + dig(seg1) * 10 + dig(seg0);
    return (v < 0) ? -1 : v;
  endfunction

  function automatic int cap(input int v);
    return (v > 9999) ? 9999 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic see(input string req, input int led0, input int val);
    chk(led[0] == led0[0], req, led[0], led0);
    chk(shown() == val, req, shown(), val);
    chk(led[1] == 1'b0, "R9", led[1], 0);
  endtask

  task automatic arm_and_light(input int n);
    see("R1", 0, 0);
    thresh = n[7:0];
    start  = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      see("R2", 0, 0);
    end
    @(negedge clk);
    see("R2", 1, 0);
  endtask

  task automatic run_case(input int n, input int m);
    int fin;
    arm_and_light(n);
    for (int t = 1; t <= m; t++) begin
      @(negedge clk);
      see("R3", 1, cap(t / T));
    end
    fin = cap((m + 2) / T);
    resp_btn = 1'b1;
    @(negedge clk);
    resp_btn = 1'b0;
    see("R5", 1, cap((m + 1) / T));
    @(negedge clk);
    see("R5", 1, fin);
    @(negedge clk);
    see("R5", 0, fin);
    repeat (10) @(negedge clk);
    see("R10", 0, fin);
    resp_btn = 1'b1;
    repeat (3) @(negedge clk);
    resp_btn = 1'b0;
    repeat (5) @(negedge clk);
    see("R6", 0, fin);
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    see("R1", 0, 0);
    chk({seg3, seg2, seg1, seg0} == {4{7'h40}}, "R8", seg0, 7'h40);
    chk(led == 2'b00, "R1", led, 0);

    run_case(0, 0);
    run_case(0, 5);
    run_case(1, 3);
    run_case(2, 8);
    run_case(3, 1);
    run_case(7, 17);
    run_case(5, 45);
    run_case(100, 40);
    run_case(255, 6);

    // R6: press pulse in the wait phase is ignored
    arm_and_light(0);
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);
    thresh = 8'd30;
    start  = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (k == 10) resp_btn = 1'b1;
      if (k == 12) resp_btn = 1'b0;
      see("R6", 0, 0);
    end
    @(negedge clk);
    see("R6", 1, 0);
    for (int t = 1; t <= 12; t++) begin
      @(negedge clk);
      see("R6", 1, t / T);
    end
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);

    // R6: button held since before the light does not stop timing
    resp_btn = 1'b1;
    repeat (3) @(negedge clk);
    arm_and_light(10);
    for (int t = 1; t <= 24; t++) begin
      @(negedge clk);
      if (t == 20) resp_btn = 1'b0;
      see("R6", 1, t / T);
    end
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);

    // R7: drop during the wait, then re-arm counts from zero
    thresh = 8'd50;
    start  = 1'b1;
    repeat (10) @(negedge clk);
    see("R7", 0, 0);
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);
    arm_and_light(50);
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);

    // R4: full sweep through every carry up to saturation
    run_case(0, 40010);
    arm_and_light(0);
    for (int t = 1; t <= 4 * 10000 + 8; t++) begin
      @(negedge clk);
      if (t >= 39996) see("R4", 1, 9999);
    end
    chk({seg3, seg2, seg1, seg0} == {4{7'h10}}, "R8", seg0, 7'h10);
    start = 1'b0;
    @(negedge clk);
    see("R7", 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule